// File: doc/BRIEF.md
# Signed Array Multiplier with Magnitude Wrapping

This block multiplies a 16-bit two's-complement operand by a 24-bit two's-complement operand and returns the full 40-bit two's-complement product. Signs are taken off first: an operand whose top bit is set is negated, so only non-negative magnitudes reach the multiplier core. The core is an unsigned carry-save array. Each row adds one partial product to the sum and carry bits of the row above. The first row needs only half adders and the later rows use full adders. A ripple-carry row at the bottom merges the remaining sum and carry vectors into the upper product bits.

The sign of the result is the exclusive OR of the two operand signs. The magnitude product is negated when that sign is set. The sign is forced to positive when the magnitude product is zero, so a zero product always comes out as positive zero, together with a clear sign flag. The arithmetic is combinational from operands to result. A single register stage with a synchronous active-high reset holds the product and the sign flag at the output, so a result appears one clock after its operands are sampled.

Top module: `smag_array_mult`

## Requirements
- R1: On the clock edge after operands are sampled, `prod_out` holds the exact signed product of `a_in` and `b_in`, as a 40-bit two's-complement value, for every operand pair.
- R2: While `rst` is high at a rising clock edge, `prod_out` and `prod_neg` are both set to 0 on that edge, whatever the operands are.
- R3: `prod_neg` is 1 exactly when the registered product is negative. It therefore always equals bit 39 of `prod_out`.
- R4: Whenever either operand is zero, the result is positive zero (`prod_out` = 0 and `prod_neg` = 0). This includes the case where the other operand is negative.
- R5: The most negative operand values are multiplied correctly. For example, -32768 times -8388608 gives +274877906944 (2^38) with `prod_neg` = 0, and -32768 times -1 gives +32768.
- R6: For nonzero operands, the result is negative exactly when one operand is negative and the other is positive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | 16 | First operand, two's complement |
| b_in | input | 24 | Second operand, two's complement |
| prod_out | output | 40 | Registered signed product, two's complement |
| prod_neg | output | 1 | Registered sign flag of the product, 1 for negative |

## Verification
The hardest situations to reach are those where the magnitude path and the sign path disagree. One is a zero magnitude product under a negative sign, which happens when a negative operand meets a zero. The other is an operand at its most negative value, whose magnitude needs the top bit of the unsigned core. Uniform random operands almost never produce either case. The stimulus therefore drives a fixed list of zero, unit, extreme and mixed-sign pairs first. It then runs ten thousand random pairs in which a share of operands is pulled toward zero, small values and the two extremes. Every result is compared against the built-in signed multiply.

// File: rtl/smag_mult_pkg.sv
package smag_mult_pkg;
  localparam int A_W_DEF = 16;
  localparam int B_W_DEF = 24;
endpackage

// File: rtl/smag_ha_cell.sv
module smag_ha_cell (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

// File: rtl/smag_fa_cell.sv
module smag_fa_cell (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic c
);
  assign s = x ^ y ^ z;
  assign c = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/smag_cond_negate.sv
// Conditional two's-complement negation: invert when en, then add en
// through a half-adder increment chain. The top bit keeps only its sum.
module smag_cond_negate #(
  parameter int W = 16
) (
  input  logic         en,
  input  logic [W-1:0] val,
  output logic [W-1:0] res
);
  logic [W-1:0] inv;
  logic [W-1:0] cy;

  assign inv   = val ^ {W{en}};
  assign cy[0] = en;

  for (genvar k = 0; k < W - 1; k++) begin : g_bit
    smag_ha_cell u_ha (
      .x(inv[k]),
      .y(cy[k]),
      .s(res[k]),
      .c(cy[k+1])
    );
  end

  assign res[W-1] = inv[W-1] ^ cy[W-1];
endmodule

// File: rtl/smag_ripple_row.sv
// Final carry-propagate row; the carry out of the top bit is dropped.
module smag_ripple_row #(
  parameter int W = 24
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);
  logic [W-1:1] rc;

  smag_ha_cell u_lsb (
    .x(x[0]),
    .y(y[0]),
    .s(sum[0]),
    .c(rc[1])
  );

  for (genvar j = 1; j < W - 1; j++) begin : g_mid
    smag_fa_cell u_fa (
      .x(x[j]),
      .y(y[j]),
      .z(rc[j]),
      .s(sum[j]),
      .c(rc[j+1])
    );
  end

  assign sum[W-1] = x[W-1] ^ y[W-1] ^ rc[W-1];
endmodule

// File: rtl/smag_csa_array.sv
// Unsigned carry-save array: one row per bit of ma, one column per bit of mb.
// Row i column j weighs i+j; the row sum shifted by one and the row carry
// both feed the next row, and the last row resolves in a ripple row.
module smag_csa_array #(
  parameter int AW = 16,
  parameter int BW = 24,
  localparam int PW = AW + BW
) (
  input  logic [AW-1:0] ma,
  input  logic [BW-1:0] mb,
  output logic [PW-1:0] prod
);
  logic [AW*BW-1:0]     s_v;
  logic [(AW-1)*BW-1:0] c_v;

  // row 0: plain partial product, no carries yet
  assign s_v[BW-1:0] = mb & {BW{ma[0]}};

  for (genvar i = 1; i < AW; i++) begin : g_row
    logic [BW-1:0] pp;
    logic [BW-1:0] up_s;
    assign pp   = mb & {BW{ma[i]}};
    assign up_s = {1'b0, s_v[(i-1)*BW+1 +: BW-1]};

    for (genvar j = 0; j < BW; j++) begin : g_col
      if (i == 1) begin : g_ha
        smag_ha_cell u_ha (
          .x(pp[j]),
          .y(up_s[j]),
          .s(s_v[i*BW+j]),
          .c(c_v[(i-1)*BW+j])
        );
      end else begin : g_fa
        smag_fa_cell u_fa (
          .x(pp[j]),
          .y(up_s[j]),
          .z(c_v[(i-2)*BW+j]),
          .s(s_v[i*BW+j]),
          .c(c_v[(i-1)*BW+j])
        );
      end
    end
  end

  for (genvar i = 0; i < AW; i++) begin : g_low
    assign prod[i] = s_v[i*BW];
  end

  logic [BW-1:0] fin_s;
  logic [BW-1:0] fin_c;
  assign fin_s = {1'b0, s_v[(AW-1)*BW+1 +: BW-1]};
  assign fin_c = c_v[(AW-2)*BW +: BW];

  smag_ripple_row #(.W(BW)) u_final (
    .x(fin_s),
    .y(fin_c),
    .sum(prod[PW-1:AW])
  );
endmodule

// File: rtl/smag_array_mult.sv
module smag_array_mult
  import smag_mult_pkg::*;
#(
  parameter int A_W = A_W_DEF,
  parameter int B_W = B_W_DEF,
  localparam int P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  output logic [P_W-1:0] prod_out,
  output logic           prod_neg
);
  logic [A_W-1:0] a_mag;
  logic [B_W-1:0] b_mag;
  logic [P_W-1:0] u_prod;
  logic [P_W-1:0] s_prod;
  logic           nonzero;
  logic           neg_c;

  // magnitudes: the most negative value maps to 1 followed by zeros, read unsigned
  smag_cond_negate #(.W(A_W)) u_abs_a (
    .en(a_in[A_W-1]),
    .val(a_in),
    .res(a_mag)
  );

  smag_cond_negate #(.W(B_W)) u_abs_b (
    .en(b_in[B_W-1]),
    .val(b_in),
    .res(b_mag)
  );

  smag_csa_array #(.AW(A_W), .BW(B_W)) u_core (
    .ma(a_mag),
    .mb(b_mag),
    .prod(u_prod)
  );

  // a zero magnitude never takes a negative sign
  assign nonzero = |u_prod;
  assign neg_c   = (a_in[A_W-1] ^ b_in[B_W-1]) & nonzero;

  smag_cond_negate #(.W(P_W)) u_restore (
    .en(neg_c),
    .val(u_prod),
    .res(s_prod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_out <= '0;
      prod_neg <= 1'b0;
    end else begin
      prod_out <= s_prod;
      prod_neg <= neg_c;
    end
  end
endmodule

// File: rtl/smag_array_mult_chk.sv
module smag_array_mult_chk #(
  parameter int A_W = 16,
  parameter int B_W = 24,
  localparam int P_W = A_W + B_W
) (
  input logic           clk,
  input logic           rst,
  input logic [A_W-1:0] a_in,
  input logic [B_W-1:0] b_in,
  input logic [P_W-1:0] prod_out,
  input logic           prod_neg
);
  logic signed [P_W-1:0] a_ext;
  logic signed [P_W-1:0] b_ext;
  logic signed [P_W-1:0] ref_p;
  logic                  a_min;
  logic                  b_min;

  assign a_ext = $signed({{B_W{a_in[A_W-1]}}, a_in});
  assign b_ext = $signed({{A_W{b_in[B_W-1]}}, b_in});
  assign ref_p = a_ext * b_ext;
  assign a_min = (a_in == {1'b1, {(A_W-1){1'b0}}});
  assign b_min = (b_in == {1'b1, {(B_W-1){1'b0}}});

  // R1
  product_match_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (prod_out == $past(ref_p)));

  // R2
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (prod_out == '0 && !prod_neg));

  // R3
  sign_flag_chk: assert property (@(posedge clk) disable iff (rst)
    prod_neg == prod_out[P_W-1]);

  // R4
  zero_positive_chk: assert property (@(posedge clk) disable iff (rst)
    (a_in == '0 || b_in == '0) |=> (prod_out == '0 && !prod_neg));

  // R5
  extreme_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (a_min && b_min) |=> (prod_out == (P_W'(1) << (P_W - 2)) && !prod_neg));

  // R6
  mixed_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (a_in != '0 && b_in != '0) |=> (prod_neg == $past(a_in[A_W-1] ^ b_in[B_W-1])));
endmodule

bind smag_array_mult smag_array_mult_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk(clk),
  .rst(rst),
  .a_in(a_in),
  .b_in(b_in),
  .prod_out(prod_out),
  .prod_neg(prod_neg)
);

// File: tb/smag_array_mult_tb_top.sv
`timescale 1ns/1ps
module smag_array_mult_tb_top;
  localparam int A_W = 16;
  localparam int B_W = 24;
  localparam int P_W = A_W + B_W;

  typedef struct {
    logic [P_W-1:0] p;
    logic           n;
    string          tag;
  } item_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [A_W-1:0] a_in = '0;
  logic [B_W-1:0] b_in = '0;
  logic [P_W-1:0] prod_out;
  logic           prod_neg;
  logic           drv_valid = 1'b0;
  bit             done = 1'b0;
  int             checks = 0;
  int             failures = 0;
  item_t          sb_q[$];

  always #4 clk = ~clk;

  smag_array_mult #(.A_W(A_W), .B_W(B_W)) dut_i (
    .clk(clk),
    .rst(rst),
    .a_in(a_in),
    .b_in(b_in),
    .prod_out(prod_out),
    .prod_neg(prod_neg)
  );

  task automatic drive(input logic [A_W-1:0] a, input logic [B_W-1:0] b, input string tag);
    longint ea;
    longint eb;
    longint pr;
    item_t  it;
    ea = longint'($signed(a));
    eb = longint'($signed(b));
    pr = ea * eb;
    it.p   = pr[P_W-1:0];
    it.n   = (pr < 0);
    it.tag = tag;
    @(negedge clk);
    a_in      = a;
    b_in      = b;
    drv_valid = 1'b1;
    sb_q.push_back(it);
  endtask

  // monitor: result registered at this posedge, compared two ns later
  initial begin
    forever begin
      bit    v;
      item_t exp_it;
      @(posedge clk);
      v = drv_valid && !rst;
      #2;
      if (v && sb_q.size() > 0) begin
        exp_it = sb_q.pop_front();
        checks++;
        if (prod_out !== exp_it.p || prod_neg !== exp_it.n) begin
          failures++;
          $display("FAIL %s a=%0d b=%0d: got prod=%0d neg=%0b, expected prod=%0d neg=%0b",
                   exp_it.tag, $signed(a_in), $signed(b_in), $signed(prod_out), prod_neg,
                   $signed(exp_it.p), exp_it.n);
        end
      end
    end
  end

  task automatic check_reset(input string tag);
    @(posedge clk);
    #2;
    checks++;
    if (prod_out !== '0 || prod_neg !== 1'b0) begin
      failures++;
      $display("FAIL %s reset: got prod=%0d neg=%0b, expected prod=0 neg=0",
               tag, $signed(prod_out), prod_neg);
    end
  endtask

  function automatic logic [A_W-1:0] pick_a(input int mode);
    case (mode)
      0: return A_W'($urandom);
      1: return A_W'($urandom_range(8) - 4);
      2: return ($urandom_range(1) == 0) ? {1'b1, {(A_W-1){1'b0}}} : {1'b0, {(A_W-1){1'b1}}};
      default: return '0;
    endcase
  endfunction

  function automatic logic [B_W-1:0] pick_b(input int mode);
    case (mode)
      0: return B_W'($urandom);
      1: return B_W'($urandom_range(8) - 4);
      2: return ($urandom_range(1) == 0) ? {1'b1, {(B_W-1){1'b0}}} : {1'b0, {(B_W-1){1'b1}}};
      default: return '0;
    endcase
  endfunction

  localparam logic [A_W-1:0] A_MIN = {1'b1, {(A_W-1){1'b0}}};
  localparam logic [A_W-1:0] A_MAX = {1'b0, {(A_W-1){1'b1}}};
  localparam logic [B_W-1:0] B_MIN = {1'b1, {(B_W-1){1'b0}}};
  localparam logic [B_W-1:0] B_MAX = {1'b0, {(B_W-1){1'b1}}};

  initial begin
    // R2: reset with nonzero operands present
    a_in = -16'sd5;
    b_in = 24'sd7;
    check_reset("R2");
    check_reset("R2");
    @(negedge clk);
    rst = 1'b0;

    // R4: zero products with negative partners
    drive('0, -24'sd1, "R4");
    drive(-16'sd1, '0, "R4");
    drive('0, B_MIN, "R4");
    drive(A_MIN, '0, "R4");
    drive('0, '0, "R4");
    drive(-16'sd77, '0, "R4");

    // R5: extreme operands
    drive(A_MIN, B_MIN, "R5");
    drive(A_MIN, 24'sd1, "R5");
    drive(A_MIN, -24'sd1, "R5");
    drive(16'sd1, B_MIN, "R5");
    drive(-16'sd1, B_MIN, "R5");
    drive(A_MAX, B_MAX, "R5");
    drive(A_MIN, B_MAX, "R5");
    drive(A_MAX, B_MIN, "R5");

    // R6 and R3: sign combinations
    drive(16'sd3, -24'sd7, "R6");
    drive(-16'sd3, 24'sd7, "R6");
    drive(-16'sd3, -24'sd7, "R6");
    drive(16'sd3, 24'sd7, "R6");
    drive(-16'sd1, 24'sd1, "R3");
    drive(-16'sd1, -24'sd1, "R3");

    // R2: reset again in mid-run
    @(negedge clk);
    drv_valid = 1'b0;
    rst  = 1'b1;
    a_in = A_MIN;
    b_in = -24'sd9;
    check_reset("R2");
    @(negedge clk);
    rst = 1'b0;

    // R1: random pairs, partly biased toward zero, small and extreme values
    for (int n = 0; n < 10000; n++) begin
      drive(pick_a($urandom_range(5) % 4), pick_b($urandom_range(5) % 4), "R1");
    end

    @(negedge clk);
    drv_valid = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule